// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It builds a table index by placing the low branch-address bits above a global history register. That register holds the resolved outcomes of the most recent branches, whatever branch produced them. The index selects one 2-bit saturating counter in a single pattern table. The upper counter bit gives the prediction.

The fetch side presents the low PC bits on the predict port. In the same cycle, with no register on the path, it gets back a taken/not-taken guess and the index that produced it. It carries that index with the branch. When the branch resolves, the back end returns the PC bits, the actual outcome and the carried index on the update port. The counter at that index is stepped toward the outcome, and the outcome is shifted into the history.

The PC field width and the history width are parameters, and the table depth follows from their sum. Setting `PC_IDX_W = 10` and `HIST_W = 4` gives the 16K-entry arrangement. The default build uses 8 PC bits, which keeps the table at 4K entries.

Top module: `cghp_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken) and the history register is zero. Every PC therefore predicts not-taken, and the low `HIST_W` bits of `pred_idx` are 0.
- R2: `pred_idx` is the concatenation `{pred_pc, history}`: the PC bits form the upper `PC_IDX_W` bits and the history forms the low `HIST_W` bits.
- R3: An update with `upd_taken = 1` sets the addressed counter to min(3, counter+1).
- R4: An update with `upd_taken = 0` sets the addressed counter to max(0, counter-1).
- R5: Each valid update shifts the history left by one and places the outcome in bit 0, with 1 meaning taken. Without a valid update the history holds its value.
- R6: An update writes the counter at `upd_idx`, the index captured at predict time, even when the history has changed since that predict. The entry selected by the current history is left alone. `upd_idx[IDX_W-1:HIST_W]` must equal `upd_pc`.
- R7: `pred_taken` is 1 exactly when the selected counter is 2 or 3.
- R8: A predict in the same cycle as an update sees the counter and history values from before that update's write.
- R9: The same PC under different history values selects different counters, so these counters train independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_IDX_W | Low branch-address bits of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | PC_IDX_W+HIST_W | Table index used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_IDX_W | Low address bits of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_idx | input | PC_IDX_W+HIST_W | Index carried from predict time |

## Verification
The assertions check on every cycle:
- the single-step saturating move of the written counter in each direction;
- the history shift, where the outcome enters bit 0, and history stability when no update is presented;
- the agreement between the PC field of `upd_idx` and `upd_pc`.

Some behaviour only shows over a sequence of events, so the bench scenarios cover it:
- that a stale captured index trains the old entry and not the one the current history selects;
- that saturation holds across repeated updates;
- that a predict and an update in the same cycle observe the pre-write state;
- that history values steer one PC onto separate counters.

// File: rtl/cghp_pkg.sv
package cghp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_TOP  = 2'd3;
  localparam ctr_t CTR_BOT  = 2'd0;

  // One saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_TOP) ? CTR_TOP : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_BOT) ? CTR_BOT : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

  // Counter values 2 and 3 vote taken.
  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur >= 2'd2;
  endfunction

endpackage

// File: rtl/cghp_history.sv
module cghp_history #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = outcome;
    end else begin : g_wide
      assign hist_d = {hist_q[HIST_W-2:0], outcome};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    hist_q <= '0;
    else if (push) hist_q <= hist_d;
  end

  assign hist = hist_q;

  assert_hist_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> hist_q[0] == $past(outcome));

  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(hist_q));

endmodule

// File: rtl/cghp_pattern_table.sv
module cghp_pattern_table
  import cghp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];
  ctr_t ctr_old;
  ctr_t ctr_new;

  assign ctr_old = tbl[wr_idx];
  assign ctr_new = ctr_step(ctr_old, wr_taken);
  // Combinational read returns the stored value, i.e. the pre-write value
  // during a same-cycle update.
  assign rd_ctr  = tbl[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_INIT;
    end else if (wr_en) begin
      tbl[wr_idx] <= ctr_new;
    end
  end

  assert_ctr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken) |=>
      tbl[$past(wr_idx)] == (($past(ctr_old) == 2'd3) ? 2'd3 : $past(ctr_old) + 2'd1));

  assert_ctr_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken) |=>
      tbl[$past(wr_idx)] == (($past(ctr_old) == 2'd0) ? 2'd0 : $past(ctr_old) - 2'd1));

endmodule

// File: rtl/cghp_predictor.sv
module cghp_predictor
  import cghp_pkg::*;
#(
  parameter int PC_IDX_W = 8,
  parameter int HIST_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PC_IDX_W-1:0]        pred_pc,
  output logic                       pred_taken,
  output logic [PC_IDX_W+HIST_W-1:0] pred_idx,
  input  logic                       upd_valid,
  input  logic [PC_IDX_W-1:0]        upd_pc,
  input  logic                       upd_taken,
  input  logic [PC_IDX_W+HIST_W-1:0] upd_idx
);

  localparam int IDX_W = PC_IDX_W + HIST_W;

  logic [HIST_W-1:0] ghist;
  ctr_t              sel_ctr;
  logic              ctr_write_evt;
  logic              hist_shift_evt;

  assign ctr_write_evt  = upd_valid;
  assign hist_shift_evt = upd_valid;

  cghp_history #(.HIST_W(HIST_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (hist_shift_evt),
    .outcome (upd_taken),
    .hist    (ghist)
  );

  assign pred_idx = {pred_pc, ghist};

  cghp_pattern_table #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_idx),
    .rd_ctr   (sel_ctr),
    .wr_en    (ctr_write_evt),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  assign pred_taken = ctr_says_taken(sel_ctr);

  assert_upd_pc_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_idx[IDX_W-1:HIST_W] == upd_pc);

endmodule

// File: tb/tb_cghp_predictor.sv
module tb_cghp_predictor;
  localparam int PCW   = 8;
  localparam int HW    = 4;
  localparam int IW    = PCW + HW;
  localparam int DEPTH = 1 << IW;
  localparam logic [IW-1:0] SCRATCH = {8'hFF, 4'h0};

  // Vector: {pc[7:0], do_update, taken}
  localparam logic [9:0] VEC [16] = '{
    {8'h10,1'b1,1'b1}, {8'h10,1'b1,1'b1}, {8'h10,1'b1,1'b1}, {8'h20,1'b1,1'b0},
    {8'h10,1'b0,1'b0}, {8'h20,1'b1,1'b1}, {8'h20,1'b1,1'b1}, {8'h21,1'b1,1'b1},
    {8'h21,1'b1,1'b1}, {8'h10,1'b1,1'b0}, {8'h10,1'b1,1'b1}, {8'h33,1'b1,1'b0},
    {8'h33,1'b1,1'b0}, {8'h20,1'b0,1'b0}, {8'h21,1'b1,1'b1}, {8'h10,1'b1,1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PCW-1:0] pred_pc = '0;
  logic          pred_taken;
  logic [IW-1:0] pred_idx;
  logic          upd_valid = 1'b0;
  logic [PCW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic [IW-1:0] upd_idx = '0;

  always #10 clk = ~clk;

  cghp_predictor #(.PC_IDX_W(PCW), .HIST_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_idx(pred_idx), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_idx(upd_idx)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [1:0]    m_ctr [DEPTH];
  logic [HW-1:0] m_hist = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [IW-1:0] idx, input logic tk);
    if (tk) begin
      if (m_ctr[idx] != 2'd3) m_ctr[idx] = m_ctr[idx] + 2'd1;
    end else begin
      if (m_ctr[idx] != 2'd0) m_ctr[idx] = m_ctr[idx] - 2'd1;
    end
    m_hist = {m_hist[HW-2:0], tk};
  endtask

  task automatic do_update(input logic [IW-1:0] idx, input logic tk);
    upd_valid = 1'b1;
    upd_idx   = idx;
    upd_pc    = idx[IW-1:HW];
    upd_taken = tk;
    @(posedge clk);
    #2;
    upd_valid = 1'b0;
    model_step(idx, tk);
    @(negedge clk);
  endtask

  task automatic set_hist(input logic [HW-1:0] h);
    for (int i = HW - 1; i >= 0; i--) do_update(SCRATCH, h[i]);
  endtask

  task automatic probe(input logic [PCW-1:0] pc, input string req);
    pred_pc = pc;
    #1;
    chk(req, 32'(pred_idx), 32'({pc, m_hist}));
    chk(req, 32'(pred_taken), 32'(m_ctr[{pc, m_hist}] >= 2'd2));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] cap;
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int p = 0; p < 4; p++) begin
      pred_pc = PCW'(p * 61);
      #1;
      chk("R1 hist", 32'(pred_idx[HW-1:0]), 32'h0);
      chk("R1 pred", 32'(pred_taken), 32'h0);
    end

    // R2 R7 R3 R4 R5: vector walk against the bench's own model
    for (int v = 0; v < 16; v++) begin
      probe(VEC[v][9:2], "R2 R7 vector");
      if (VEC[v][1]) do_update({VEC[v][9:2], m_hist}, VEC[v][0]);
    end

    // R3: saturation at 3
    set_hist(4'b1010);
    cap = {8'h3C, 4'b1010};
    repeat (5) do_update(cap, 1'b1);
    set_hist(4'b1010); pred_pc = 8'h3C; #1;
    chk("R3 sat top", 32'(pred_taken), 32'h1);
    do_update(cap, 1'b0);
    set_hist(4'b1010); #1;
    chk("R3 at 2", 32'(pred_taken), 32'h1);
    do_update(cap, 1'b0);
    set_hist(4'b1010); #1;
    chk("R3 at 1", 32'(pred_taken), 32'h0);

    // R4: saturation at 0
    cap = {8'h5A, 4'b0110};
    repeat (3) do_update(cap, 1'b0);
    do_update(cap, 1'b1);
    set_hist(4'b0110); pred_pc = 8'h5A; #1;
    chk("R4 from 0 to 1", 32'(pred_taken), 32'h0);
    do_update(cap, 1'b1);
    set_hist(4'b0110); #1;
    chk("R4 to 2", 32'(pred_taken), 32'h1);

    // R5: history shift order and hold
    set_hist(4'b0000);
    do_update(SCRATCH, 1'b1); do_update(SCRATCH, 1'b1);
    do_update(SCRATCH, 1'b0); do_update(SCRATCH, 1'b1);
    pred_pc = 8'h01; #1;
    chk("R5 shift", 32'(pred_idx[HW-1:0]), 32'hD);
    repeat (3) @(negedge clk);
    #1;
    chk("R5 hold", 32'(pred_idx[HW-1:0]), 32'hD);

    // R6 R9: stale captured index, history steering
    set_hist(4'b0011);
    pred_pc = 8'h11; #1;
    cap = pred_idx;
    chk("R6 capture", 32'(cap), 32'({8'h11, 4'b0011}));
    do_update(SCRATCH, 1'b1);
    do_update(cap, 1'b1);
    do_update(cap, 1'b1);
    set_hist(4'b0011); pred_pc = 8'h11; #1;
    chk("R6 old entry trained", 32'(pred_taken), 32'h1);
    set_hist(4'b0111); #1;
    chk("R9 other history untouched", 32'(pred_taken), 32'h0);
    probe(8'h11, "R9 model");

    // R8: same-cycle predict and update see pre-write state
    set_hist(4'b0101);
    pred_pc   = 8'h77;
    upd_valid = 1'b1;
    upd_idx   = {8'h77, 4'b0101};
    upd_pc    = 8'h77;
    upd_taken = 1'b1;
    #1;
    chk("R8 pred old", 32'(pred_taken), 32'h0);
    chk("R8 idx old hist", 32'(pred_idx), 32'({8'h77, 4'b0101}));
    @(posedge clk);
    #2;
    upd_valid = 1'b0;
    model_step({8'h77, 4'b0101}, 1'b1);
    @(negedge clk);
    set_hist(4'b0101); pred_pc = 8'h77; #1;
    chk("R8 written after", 32'(pred_taken), 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule